// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the clock line of an I2C master. A 32-bit timing word sets a shared prescaler and four delays counted in prescaled units. From these the block produces an open-drain pull-down request for SCL, a one-cycle strobe that tells the bit sequencer when to change SDA, and a one-cycle strobe that tells it when to capture SDA.

Each bit has a low phase and a high phase. During the low phase a hold counter places the SDA change strobe after the falling edge. A setup counter then keeps SCL low long enough after that strobe, and the low counter sets the minimum low time; the low phase ends only when both have expired. After SCL is released, the high counter waits for the sampled line to read high, so a slave can stretch the clock. The sample strobe falls in the middle of the high phase. The timing word is captured only while the enable input is low, and the captured copy is held while the enable input is high.

The sequencer raises `run_i` to clock bits. When it lowers `run_i`, the bit in progress completes and the block then idles with SCL released.

Top module: `i2c_scl_timing`

## Requirements
- R1: Timing word fields: prescaler P in bits 31:28, setup count U in bits 23:20, hold count D in bits 19:16, high count H in bits 15:8 and low count L in bits 7:0. Bits 27:24 have no effect.
- R2: The low phase is the run of cycles with `scl_low_o`=1. It lasts (P+1)·max(L+1, D+U+1) clock cycles.
- R3: After SCL is released, the high phase starts in the cycle after the first cycle in which `scl_i` reads 1. It lasts (P+1)·(H+1) cycles, and if `run_i` is 1 at its end the next low phase follows directly.
- R4: `sda_change_o` pulses for exactly one cycle per low phase, at cycle index D·(P+1), where the first low cycle has index 0.
- R5: SCL is not released earlier than (U+1)·(P+1) cycles after the `sda_change_o` cycle, even when the low count has already expired.
- R6: `sda_sample_o` pulses once per high phase, at cycle index (H>>1)·(P+1) of that phase, while SCL is released.
- R7: While an external device holds `scl_i` at 0 after release, the high phase does not start and no sample strobe occurs. The high phase that follows keeps its full length.
- R8: The timing word is captured on every clock edge at which `enable_i` is 0. Changes to `timing_i` while `enable_i` is 1 have no effect on any phase length.
- R9: From the cycle after `enable_i` is seen at 0, SCL is released and both strobes stay at 0. When the block is enabled again it starts from a fresh low phase.
- R10: When `run_i` is 0 at the end of a high phase, the block idles with SCL released and emits no events. The first low cycle is the cycle after `enable_i` and `run_i` are both seen at 1 while idle.
- R11: After reset, SCL is released and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Peripheral enable; 0 loads the timing word and idles the block |
| timing_i | input | 32 | Timing word (fields as in R1) |
| run_i | input | 1 | Sequencer request to clock bits |
| scl_i | input | 1 | Synchronised level of the SCL line |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_change_o | output | 1 | One-cycle strobe: sequencer may change SDA |
| sda_sample_o | output | 1 | One-cycle strobe: sequencer captures SDA |

## Verification
Two coincidences are possible. With a hold count of 0, the SDA change strobe lands in the same cycle as the SCL falling edge. With a high count of 0 or 1, the sample strobe lands in the first high cycle, directly behind the line being seen high. One timing word sets both fields to 0 with a prescaler of 2. For that word the scoreboard expects the falling-edge event and the change event at the same cycle number, and the sample event one cycle after the release event. Any shift of either event by one cycle is reported with its actual and expected cycle.

// File: rtl/i2c_scl_timing_pkg.sv
package i2c_scl_timing_pkg;

  localparam int REG_W = 32;
  localparam int PRE_W = 4;
  localparam int DEL_W = 4;
  localparam int PER_W = 8;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic [DEL_W-1:0] setup;
    logic [DEL_W-1:0] hold;
    logic [PER_W-1:0] high;
    logic [PER_W-1:0] low;
  } tmg_cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAIT,
    PH_HIGH
  } phase_e;

  // field positions are decoded by software, keep them fixed
  function automatic tmg_cfg_t unpack_cfg(input logic [REG_W-1:0] r);
    tmg_cfg_t c;
    c.presc = r[31:28];
    c.setup = r[23:20];
    c.hold  = r[19:16];
    c.high  = r[15:8];
    c.low   = r[7:0];
    return c;
  endfunction

endpackage

// File: rtl/i2c_scl_prescaler.sv
module i2c_scl_prescaler #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o
);

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == limit_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (tick_o)             cnt_q <= '0;
    else                         cnt_q <= cnt_q + W'(1);
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !restart_i && !$past(restart_i) |-> cnt_q <= limit_i); // R2

endmodule

// File: rtl/i2c_scl_unit_cnt.sv
module i2c_scl_unit_cnt #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o,
  output logic         fin_o
);

  logic [W-1:0] cnt_q;
  logic         step;

  assign step   = en_i && tick_i && (cnt_q != limit_i);
  assign done_o = (cnt_q == limit_i);
  // expires at the end of this cycle
  assign fin_o  = done_o || (en_i && tick_i && ((cnt_q + W'(1)) == limit_i));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + W'(1);
  end

  AST_UNIT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && done_o |=> clear_i || $stable(cnt_q) || $changed(limit_i)); // R2

endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing
  import i2c_scl_timing_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [REG_W-1:0] timing_i,
  input  logic             run_i,
  input  logic             scl_i,
  output logic             scl_low_o,
  output logic             sda_change_o,
  output logic             sda_sample_o
);

  localparam int PER_CNT_W = PER_W + 1;
  localparam int DEL_CNT_W = DEL_W + 1;

  tmg_cfg_t cfg_q;
  phase_e   state_q, state_d;
  logic     restart, in_low, in_high;
  logic     tick;
  logic [PRE_W-1:0] pre_cnt;

  logic [PER_CNT_W-1:0] low_lim, high_lim, low_cnt, high_cnt;
  logic [DEL_CNT_W-1:0] set_lim, set_cnt;
  logic [DEL_W-1:0]     hold_cnt;
  logic low_done, low_fin, high_done, high_fin;
  logic hold_done, hold_fin, set_done, set_fin;
  logic fired_q, fire, set_en;

  // shadow copy: loads only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_q <= '0;
    else if (!enable_i) cfg_q <= unpack_cfg(timing_i);
  end

  assign in_low  = (state_q == PH_LOW);
  assign in_high = (state_q == PH_HIGH);

  always_comb begin
    state_d = state_q;
    if (!enable_i) state_d = PH_IDLE;
    else begin
      unique case (state_q)
        PH_IDLE: if (run_i)              state_d = PH_LOW;
        PH_LOW:  if (low_fin && set_fin) state_d = PH_WAIT;
        PH_WAIT: if (scl_i)              state_d = PH_HIGH;
        PH_HIGH: if (high_fin)           state_d = run_i ? PH_LOW : PH_IDLE;
        default:                         state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_IDLE;
    else         state_q <= state_d;
  end

  assign restart = (state_d != state_q);

  i2c_scl_prescaler #(.W(PRE_W)) i_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (in_low || in_high),
    .limit_i   (cfg_q.presc),
    .cnt_o     (pre_cnt),
    .tick_o    (tick)
  );

  assign low_lim  = {1'b0, cfg_q.low}  + PER_CNT_W'(1);
  assign high_lim = {1'b0, cfg_q.high} + PER_CNT_W'(1);
  assign set_lim  = {1'b0, cfg_q.setup} + DEL_CNT_W'(1);

  i2c_scl_unit_cnt #(.W(PER_CNT_W)) i_low_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart || !in_low),
    .en_i    (1'b1),
    .tick_i  (tick),
    .limit_i (low_lim),
    .cnt_o   (low_cnt),
    .done_o  (low_done),
    .fin_o   (low_fin)
  );

  i2c_scl_unit_cnt #(.W(PER_CNT_W)) i_high_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart || !in_high),
    .en_i    (1'b1),
    .tick_i  (tick),
    .limit_i (high_lim),
    .cnt_o   (high_cnt),
    .done_o  (high_done),
    .fin_o   (high_fin)
  );

  i2c_scl_unit_cnt #(.W(DEL_W)) i_hold_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart || !in_low),
    .en_i    (1'b1),
    .tick_i  (tick),
    .limit_i (cfg_q.hold),
    .cnt_o   (hold_cnt),
    .done_o  (hold_done),
    .fin_o   (hold_fin)
  );

  assign fire   = in_low && hold_done && !fired_q;
  assign set_en = fired_q || fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 fired_q <= 1'b0;
    else if (restart || !in_low) fired_q <= 1'b0;
    else if (fire)               fired_q <= 1'b1;
  end

  // setup window opens in the strobe cycle
  i2c_scl_unit_cnt #(.W(DEL_CNT_W)) i_set_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart || !in_low),
    .en_i    (set_en),
    .tick_i  (tick),
    .limit_i (set_lim),
    .cnt_o   (set_cnt),
    .done_o  (set_done),
    .fin_o   (set_fin)
  );

  assign scl_low_o    = in_low;
  assign sda_change_o = fire;
  assign sda_sample_o = in_high && (pre_cnt == '0) &&
                        (high_cnt == PER_CNT_W'(cfg_q.high[PER_W-1:1]));

  AST_CHG_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_change_o |-> scl_low_o); // R4

  AST_ONE_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_change_o |=> !sda_change_o); // R4

  AST_SMP_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_sample_o |-> !scl_low_o); // R6

  AST_SETUP_BEFORE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_low_o) && $past(enable_i) |-> $past(fired_q) && $past(set_fin)); // R5

  AST_HIGH_AFTER_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_high && $past(state_q) == PH_WAIT |-> $past(scl_i)); // R7

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && $past(enable_i) |-> $stable(cfg_q)); // R8

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !scl_low_o && !sda_change_o && !sda_sample_o); // R9

endmodule

// File: tb/test_i2c_scl_timing.sv
module test_i2c_scl_timing;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        run = 1'b0;
  logic [31:0] timing = '0;
  logic        scl_low, chg, smp;
  logic        ext;
  logic        scl_line;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  int stretch = 0;
  int ext_left = 0;
  logic low_prev = 1'b0;

  int    exp_kind[$];
  int    exp_cyc[$];
  string exp_tag[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign ext      = (ext_left > 0);
  assign scl_line = ~(scl_low | ext);

  i2c_scl_timing i_i2c_scl_timing (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .enable_i     (enable),
    .timing_i     (timing),
    .run_i        (run),
    .scl_i        (scl_line),
    .scl_low_o    (scl_low),
    .sda_change_o (chg),
    .sda_sample_o (smp)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // kinds: 0 SCL fall, 1 change strobe, 2 SCL release, 3 sample strobe
  task automatic seen(input int kind);
    if (exp_kind.size() == 0) begin
      check(1'b0, "R10", $sformatf("unexpected event kind %0d", kind), cyc, -1);
    end else begin
      int k, c;
      string t;
      k = exp_kind.pop_front();
      c = exp_cyc.pop_front();
      t = exp_tag.pop_front();
      check(k == kind && c == cyc, t,
            $sformatf("event kind %0d (expected kind %0d) cycle", kind, k), cyc, c);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (scl_low && !low_prev) seen(0);
      if (chg)                  seen(1);
      if (!scl_low && low_prev) seen(2);
      if (smp)                  seen(3);
    end
    if (!scl_low && low_prev && stretch > 0) ext_left = stretch;
    else if (ext_left > 0)                   ext_left = ext_left - 1;
    low_prev = scl_low;
  end

  task automatic push(input int k, input int c, input string t);
    exp_kind.push_back(k);
    exp_cyc.push_back(c);
    exp_tag.push_back(t);
  endtask

  // driver: computes every event cycle from the requirements
  task automatic run_bits(input logic [31:0] val, input int nbits,
                          input int s, input string tag);
    int u, l, h, hd, su, nlow, nhigh, f, last_smp, mx;
    u  = int'(val[31:28]) + 1;
    su = int'(val[23:20]);
    hd = int'(val[19:16]);
    h  = int'(val[15:8]);
    l  = int'(val[7:0]);
    mx = (l + 1 > hd + su + 1) ? l + 1 : hd + su + 1;
    nlow  = u * mx;
    nhigh = u * (h + 1);
    @(negedge clk);
    enable  = 1'b0;
    run     = 1'b0;
    timing  = val;
    stretch = s;
    repeat (2) @(negedge clk);
    f = cyc + 1;                                   // R10 start latency
    last_smp = 0;
    for (int b = 0; b < nbits; b++) begin
      push(0, f, (b == 0) ? "R10" : "R3");
      push(1, f + hd * u, "R4");
      push(2, f + nlow, (l + 1 >= hd + su + 1) ? "R2" : "R5");
      last_smp = f + nlow + 1 + s + (h >> 1) * u;
      push(3, last_smp, (s > 0) ? "R7" : "R6");
      f = f + nlow + 1 + s + nhigh;
    end
    enable = 1'b1;
    run    = 1'b1;
    @(negedge clk);
    timing = ~val;                                 // R8: must be ignored
    while (cyc < last_smp) @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < 4000 && exp_kind.size() > 0; i++) @(negedge clk);
    check(exp_kind.size() == 0, tag, "events still pending", exp_kind.size(), 0);
    repeat (4) @(negedge clk);
    check(scl_low == 1'b0, "R10", "SCL released after run drop", scl_low, 0);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 60000) begin
      errors++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 60000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_low == 1'b0, "R11", "scl_low after reset", scl_low, 0);
    check(chg == 1'b0, "R11", "change strobe after reset", chg, 0);
    check(smp == 1'b0, "R11", "sample strobe after reset", smp, 0);
    mon_en = 1'b1;

    run_bits(32'h0001_0203, 3, 0, "R2");   // low count dominates
    run_bits(32'h1F22_0301, 2, 3, "R5");   // R1 bits 27:24 set; setup dominates; R7 stretch
    run_bits(32'h2000_0002, 3, 0, "R4");   // fall+change same cycle, sample in first high cycle
    run_bits(32'h3013_0507, 2, 1, "R7");   // larger prescaler, short stretch

    // R9: enable drop in the middle of a low phase
    mon_en = 1'b0;
    @(negedge clk);
    enable = 1'b0;
    timing = 32'h0001_0203;
    stretch = 0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    run    = 1'b1;
    repeat (3) @(negedge clk);
    check(scl_low == 1'b1, "R9", "low phase running before abort", scl_low, 1);
    enable = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(scl_low == 1'b0 && chg == 1'b0 && smp == 1'b0, "R9",
            "outputs quiet while disabled", {scl_low, chg, smp}, 0);
    end
    run = 1'b0;
    @(negedge clk);
    mon_en = 1'b1;
    run_bits(32'h0001_0203, 1, 0, "R9");   // fresh start after re-enable

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule